// File: doc/BRIEF.md
# Operand-Capturing Reservation Station

This block is the waiting pool that sits between an in-order decoder and a single out-of-order execution port. The decoder writes each issued operation into a free slot. A slot holds the opcode, the destination tag, an age (sequence) tag and two source operands. A source is either already known, so it is stored as a value and marked ready, or it still waits for a producer, so it is stored as a producer tag and marked not ready.

Every cycle, each waiting source compares its tag with the single tagged writeback broadcast. On a match it copies the broadcast data and becomes ready. An operation being written in the same cycle makes the same comparison on its way in, so a broadcast that lands during insertion is not missed. Among the slots whose two sources are ready, taking the current broadcast into account, the one with the smallest sequence tag goes to the execution port that same cycle. Its slot is released at the next clock edge. A full flag stalls the decoder once no slot is free, and a flush input empties the pool.

Top module: `rs_station`

## Requirements
- R1: After reset, no slot is occupied: `full_o` is 0 and `disp_valid_o` is 0.
- R2: An operation inserted with both sources marked ready is dispatched in the cycle after insertion, with its stored opcode, destination and source values on the dispatch outputs.
- R3: A waiting source captures `wb_data_i` in any cycle where `wb_valid_i` is 1 and `wb_tag_i` equals its producer tag. A broadcast with any other tag leaves it waiting.
- R4: An operation is never dispatched while either of its sources is still not ready.
- R5: When the last missing source of an occupied slot matches the broadcast in the current cycle, that slot can be dispatched in the same cycle, and the broadcast data appears directly on the matching dispatch operand output.
- R6: A dispatched slot is released at the next clock edge and is never dispatched a second time.
- R7: `full_o` is 1 exactly when all ENTRIES slots are occupied. An insertion request made while `full_o` is 1 is dropped.
- R8: When several slots are ready, the slot with the numerically smallest sequence tag is dispatched. Sequence tags are treated as unsigned and are assumed unique.
- R9: A source written with ready=0 whose tag matches the broadcast in the insertion cycle is stored as ready, holding the broadcast data.
- R10: In a cycle where `flush_i` is 1, nothing is dispatched, any insertion request is dropped, and every slot is empty from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Empty every slot |
| ins_valid_i | input | 1 | Insert request from the decoder |
| ins_op_i | input | 4 | Opcode of the inserted operation |
| ins_dst_i | input | 5 | Destination tag of the inserted operation |
| ins_seq_i | input | SEQ_W | Age tag; a smaller value is older |
| ins_a_rdy_i | input | 1 | Source A is already known |
| ins_a_val_i | input | 16 | Source A value when ready |
| ins_a_tag_i | input | 5 | Source A producer tag when waiting |
| ins_b_rdy_i | input | 1 | Source B is already known |
| ins_b_val_i | input | 16 | Source B value when ready |
| ins_b_tag_i | input | 5 | Source B producer tag when waiting |
| full_o | output | 1 | No free slot; stall the decoder |
| wb_valid_i | input | 1 | Writeback broadcast present |
| wb_tag_i | input | 5 | Tag of the broadcast result |
| wb_data_i | input | 16 | Broadcast result data |
| disp_valid_o | output | 1 | An operation is sent to the execution port |
| disp_op_o | output | 4 | Opcode of the dispatched operation |
| disp_dst_o | output | 5 | Destination tag of the dispatched operation |
| disp_a_o | output | 16 | Source A value of the dispatched operation |
| disp_b_o | output | 16 | Source B value of the dispatched operation |

## Verification
The assertions check a set of rules on every cycle. A grant always goes to a requesting slot, and no requesting slot is older than the granted one. A slot dispatched without a broadcast had both sources stored as ready. A granted slot is empty on the next cycle. A full pool gains no slot, and a flush leaves every slot empty. Three properties need the bench's timed scenarios: the cycle in which dispatch occurs for each mix of ready-at-insert, caught-at-insert and caught-later sources; the same-cycle forwarding of bus data; and the drain order by age after a single broadcast wakes several slots at once.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int DATA_W = 16;
    localparam int TAG_W  = 5;
    localparam int OP_W   = 4;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [OP_W-1:0]   op_t;

    // One source operand: a value once ready, otherwise the producer tag
    typedef struct packed {
        logic  rdy;
        data_t val;
        tag_t  tag;
    } src_t;
endpackage

// File: rtl/rs_wakeup.sv
module rs_wakeup
    import rs_pkg::*;
(
    input  src_t  src_i,
    input  logic  wb_valid_i,
    input  tag_t  wb_tag_i,
    input  data_t wb_data_i,
    output src_t  src_o
);
    logic match;

    always_comb begin
        match = !src_i.rdy && wb_valid_i && (wb_tag_i == src_i.tag);
        src_o = src_i;
        if (match) begin
            src_o.rdy = 1'b1;
            src_o.val = wb_data_i;
        end
    end
endmodule

// File: rtl/rs_alloc.sv
module rs_alloc #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     busy_i,
    output logic             any_free_o,
    output logic [IDX_W-1:0] free_idx_o
);
    always_comb begin
        any_free_o = 1'b0;
        free_idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy_i[i]) begin
                any_free_o = 1'b1;
                free_idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rs_picker.sv
module rs_picker #(
    parameter int N     = 4,
    parameter int SEQ_W = 6,
    parameter int IDX_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N-1:0]       req_i,
    input  logic [N*SEQ_W-1:0] seq_i,
    output logic               gnt_valid_o,
    output logic [IDX_W-1:0]   gnt_idx_o
);
    logic [SEQ_W-1:0] best_seq;
    logic             older_seen;

    always_comb begin
        gnt_valid_o = 1'b0;
        gnt_idx_o   = '0;
        best_seq    = '1;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && (!gnt_valid_o || seq_i[i*SEQ_W +: SEQ_W] < best_seq)) begin
                gnt_valid_o = 1'b1;
                gnt_idx_o   = IDX_W'(i);
                best_seq    = seq_i[i*SEQ_W +: SEQ_W];
            end
        end
    end

    // Independent scan: is any requester strictly older than the grant?
    always_comb begin
        older_seen = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && seq_i[i*SEQ_W +: SEQ_W] < seq_i[gnt_idx_o*SEQ_W +: SEQ_W])
                older_seen = 1'b1;
        end
    end

    assert_grant_is_requester_R8: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid_o |-> req_i[gnt_idx_o]);

    assert_grant_is_oldest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid_o |-> !older_seen);

    assert_grant_when_any_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i != '0) |-> gnt_valid_o);
endmodule

// File: rtl/rs_station.sv
module rs_station
    import rs_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int SEQ_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             ins_valid_i,
    input  logic [OP_W-1:0]  ins_op_i,
    input  logic [TAG_W-1:0] ins_dst_i,
    input  logic [SEQ_W-1:0] ins_seq_i,
    input  logic             ins_a_rdy_i,
    input  logic [DATA_W-1:0] ins_a_val_i,
    input  logic [TAG_W-1:0] ins_a_tag_i,
    input  logic             ins_b_rdy_i,
    input  logic [DATA_W-1:0] ins_b_val_i,
    input  logic [TAG_W-1:0] ins_b_tag_i,
    output logic             full_o,
    input  logic             wb_valid_i,
    input  logic [TAG_W-1:0] wb_tag_i,
    input  logic [DATA_W-1:0] wb_data_i,
    output logic             disp_valid_o,
    output logic [OP_W-1:0]  disp_op_o,
    output logic [TAG_W-1:0] disp_dst_o,
    output logic [DATA_W-1:0] disp_a_o,
    output logic [DATA_W-1:0] disp_b_o
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic             vld;
        op_t              op;
        tag_t             dst;
        logic [SEQ_W-1:0] seq;
        src_t             a;
        src_t             b;
    } slot_t;

    typedef struct packed {
        slot_t [ENTRIES-1:0] slot;
    } state_t;

    state_t st_q, st_d;

    src_t a_now [ENTRIES];
    src_t b_now [ENTRIES];
    src_t ins_a_raw, ins_b_raw, ins_a_now, ins_b_now;

    logic [ENTRIES-1:0]       vld_q;
    logic [ENTRIES-1:0]       req;
    logic [ENTRIES*SEQ_W-1:0] seq_flat;
    logic                     gnt_valid;
    logic [IDX_W-1:0]         gnt_idx;
    logic                     any_free;
    logic [IDX_W-1:0]         free_idx;

    // Per-slot snoop of the writeback broadcast
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        rs_wakeup u_wake_a (
            .src_i      (st_q.slot[g].a),
            .wb_valid_i (wb_valid_i),
            .wb_tag_i   (wb_tag_i),
            .wb_data_i  (wb_data_i),
            .src_o      (a_now[g])
        );
        rs_wakeup u_wake_b (
            .src_i      (st_q.slot[g].b),
            .wb_valid_i (wb_valid_i),
            .wb_tag_i   (wb_tag_i),
            .wb_data_i  (wb_data_i),
            .src_o      (b_now[g])
        );
    end

    // Incoming operation snoops the same broadcast
    always_comb begin
        ins_a_raw.rdy = ins_a_rdy_i;
        ins_a_raw.val = ins_a_val_i;
        ins_a_raw.tag = ins_a_tag_i;
        ins_b_raw.rdy = ins_b_rdy_i;
        ins_b_raw.val = ins_b_val_i;
        ins_b_raw.tag = ins_b_tag_i;
    end

    rs_wakeup u_wake_ins_a (
        .src_i      (ins_a_raw),
        .wb_valid_i (wb_valid_i),
        .wb_tag_i   (wb_tag_i),
        .wb_data_i  (wb_data_i),
        .src_o      (ins_a_now)
    );
    rs_wakeup u_wake_ins_b (
        .src_i      (ins_b_raw),
        .wb_valid_i (wb_valid_i),
        .wb_tag_i   (wb_tag_i),
        .wb_data_i  (wb_data_i),
        .src_o      (ins_b_now)
    );

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            vld_q[i] = st_q.slot[i].vld;
            req[i]   = st_q.slot[i].vld && a_now[i].rdy && b_now[i].rdy && !flush_i;
            seq_flat[i*SEQ_W +: SEQ_W] = st_q.slot[i].seq;
        end
    end

    rs_picker #(
        .N     (ENTRIES),
        .SEQ_W (SEQ_W),
        .IDX_W (IDX_W)
    ) u_picker (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .seq_i       (seq_flat),
        .gnt_valid_o (gnt_valid),
        .gnt_idx_o   (gnt_idx)
    );

    rs_alloc #(
        .N     (ENTRIES),
        .IDX_W (IDX_W)
    ) u_alloc (
        .busy_i     (vld_q),
        .any_free_o (any_free),
        .free_idx_o (free_idx)
    );

    assign full_o = !any_free;

    // Dispatch outputs, with bus data forwarded through the wakeup view
    always_comb begin
        disp_valid_o = gnt_valid;
        disp_op_o    = st_q.slot[gnt_idx].op;
        disp_dst_o   = st_q.slot[gnt_idx].dst;
        disp_a_o     = a_now[gnt_idx].val;
        disp_b_o     = b_now[gnt_idx].val;
    end

    // Next-state
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < ENTRIES; i++) begin
            st_d.slot[i].a = a_now[i];
            st_d.slot[i].b = b_now[i];
        end
        if (gnt_valid)
            st_d.slot[gnt_idx].vld = 1'b0;
        if (ins_valid_i && any_free && !flush_i) begin
            st_d.slot[free_idx].vld = 1'b1;
            st_d.slot[free_idx].op  = ins_op_i;
            st_d.slot[free_idx].dst = ins_dst_i;
            st_d.slot[free_idx].seq = ins_seq_i;
            st_d.slot[free_idx].a   = ins_a_now;
            st_d.slot[free_idx].b   = ins_b_now;
        end
        if (flush_i) begin
            for (int i = 0; i < ENTRIES; i++)
                st_d.slot[i].vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_no_dispatch_unready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid_o && !wb_valid_i) |->
            (st_q.slot[gnt_idx].a.rdy && st_q.slot[gnt_idx].b.rdy));

    assert_slot_freed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid_o |=> !vld_q[$past(gnt_idx)]);

    assert_full_blocks_insert_R7: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |=> ((vld_q & ~$past(vld_q)) == '0));

    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (vld_q == '0));

    assert_flush_no_dispatch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |-> !disp_valid_o);
endmodule

// File: tb/rs_station_bench.sv
module rs_station_bench;
    import rs_pkg::*;

    localparam int ENTRIES = 4;
    localparam int SEQ_W   = 6;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        flush_i;
    logic        ins_valid_i;
    op_t         ins_op_i;
    tag_t        ins_dst_i;
    logic [SEQ_W-1:0] ins_seq_i;
    logic        ins_a_rdy_i, ins_b_rdy_i;
    data_t       ins_a_val_i, ins_b_val_i;
    tag_t        ins_a_tag_i, ins_b_tag_i;
    logic        full_o;
    logic        wb_valid_i;
    tag_t        wb_tag_i;
    data_t       wb_data_i;
    logic        disp_valid_o;
    op_t         disp_op_o;
    tag_t        disp_dst_o;
    data_t       disp_a_o, disp_b_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rs_station #(.ENTRIES(ENTRIES), .SEQ_W(SEQ_W)) u_rs_station (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
        .ins_valid_i(ins_valid_i), .ins_op_i(ins_op_i), .ins_dst_i(ins_dst_i),
        .ins_seq_i(ins_seq_i),
        .ins_a_rdy_i(ins_a_rdy_i), .ins_a_val_i(ins_a_val_i), .ins_a_tag_i(ins_a_tag_i),
        .ins_b_rdy_i(ins_b_rdy_i), .ins_b_val_i(ins_b_val_i), .ins_b_tag_i(ins_b_tag_i),
        .full_o(full_o),
        .wb_valid_i(wb_valid_i), .wb_tag_i(wb_tag_i), .wb_data_i(wb_data_i),
        .disp_valid_o(disp_valid_o), .disp_op_o(disp_op_o), .disp_dst_o(disp_dst_o),
        .disp_a_o(disp_a_o), .disp_b_o(disp_b_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        flush_i = 0; ins_valid_i = 0; ins_op_i = '0; ins_dst_i = '0; ins_seq_i = '0;
        ins_a_rdy_i = 0; ins_a_val_i = '0; ins_a_tag_i = '0;
        ins_b_rdy_i = 0; ins_b_val_i = '0; ins_b_tag_i = '0;
        wb_valid_i = 0; wb_tag_i = '0; wb_data_i = '0;
    endtask

    task automatic bus(input tag_t t, input data_t d);
        wb_valid_i = 1; wb_tag_i = t; wb_data_i = d;
    endtask

    task automatic insert(input logic [SEQ_W-1:0] s, input logic ar, input data_t av, input tag_t at,
                          input logic br, input data_t bv, input tag_t bt);
        ins_valid_i = 1; ins_seq_i = s; ins_op_i = op_t'(s); ins_dst_i = tag_t'(s + 3);
        ins_a_rdy_i = ar; ins_a_val_i = av; ins_a_tag_i = at;
        ins_b_rdy_i = br; ins_b_val_i = bv; ins_b_tag_i = bt;
    endtask

    // Inputs change 1 ns after the rising edge; outputs are read at the falling edge
    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic mid();
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        mid();
        check("R1", "full after reset", full_o, 0);
        check("R1", "disp_valid after reset", disp_valid_o, 0);
        tick();

        // Sweep: source mode 0 = ready at insert, 1 = caught during insert, 2 = caught later
        for (int ma = 0; ma < 3; ma++) begin
            for (int mb = 0; mb < 3; mb++) begin
                data_t va, vb;
                tag_t  ta, tb;
                int    e;
                string rq;
                va = data_t'(16'h1000 + ma * 16 + mb);
                vb = data_t'(16'h2000 + ma * 16 + mb);
                ta = 5'd1;
                tb = 5'd2;
                if (ma == 1 && mb == 1) begin tb = 5'd1; vb = va; end
                idle();
                insert(SEQ_W'(ma * 3 + mb), ma == 0, (ma == 0) ? va : '0, ta,
                       mb == 0, (mb == 0) ? vb : '0, tb);
                if (ma == 1) bus(ta, va);
                else if (mb == 1) bus(tb, vb);
                mid();
                check("R4", "disp_valid in insert cycle", disp_valid_o, 0);
                tick();
                e = (mb == 2) ? 4 : ((ma == 2) ? 3 : 2);
                if (ma == 2 || mb == 2) rq = "R5";
                else if (ma == 1 || mb == 1) rq = "R9";
                else rq = "R2";
                for (int c = 2; c <= 5; c++) begin
                    idle();
                    if (c == 2) bus(5'd9, 16'hDEAD);
                    if (c == 3 && ma == 2) bus(ta, va);
                    if (c == 4 && mb == 2) bus(tb, vb);
                    mid();
                    if (c < e)
                        check("R4", "disp_valid while waiting (R3 other tag ignored)", disp_valid_o, 0);
                    else if (c == e) begin
                        check(rq, "disp_valid", disp_valid_o, 1);
                        check(rq, "disp_a", disp_a_o, va);
                        check(rq, "disp_b", disp_b_o, vb);
                        check("R2", "disp_op", disp_op_o, 32'(ma * 3 + mb));
                        check("R2", "disp_dst", disp_dst_o, 32'(ma * 3 + mb + 3));
                    end else
                        check("R6", "no second dispatch", disp_valid_o, 0);
                    tick();
                end
            end
        end

        // Fill, blocked insert, then one broadcast wakes all; drain by age
        begin
            int order [4];
            order = '{1, 3, 7, 10};
            idle(); insert(6'd10, 0, '0, 5'd5, 1, 16'd10, 5'd0); tick();
            idle(); insert(6'd3,  0, '0, 5'd5, 1, 16'd3,  5'd0); tick();
            idle(); insert(6'd7,  0, '0, 5'd5, 1, 16'd7,  5'd0); tick();
            idle(); insert(6'd1,  0, '0, 5'd5, 1, 16'd1,  5'd0);
            mid();
            check("R7", "full with three occupied", full_o, 0);
            tick();
            idle(); insert(6'd0, 1, 16'h00EE, 5'd0, 1, 16'h00EE, 5'd0);
            mid();
            check("R7", "full with four occupied", full_o, 1);
            check("R4", "no dispatch while all waiting", disp_valid_o, 0);
            tick();
            idle();
            mid();
            check("R7", "still full after dropped insert", full_o, 1);
            check("R7", "dropped insert not dispatched", disp_valid_o, 0);
            tick();
            for (int k = 0; k < 4; k++) begin
                idle();
                if (k == 0) bus(5'd5, 16'h0055);
                mid();
                check("R8", "disp_valid during drain", disp_valid_o, 1);
                check("R8", "oldest dispatched first", disp_b_o, 32'(order[k]));
                check(k == 0 ? "R5" : "R3", "captured A value", disp_a_o, 32'h55);
                if (k == 1) check("R7", "full drops after release", full_o, 0);
                tick();
            end
            idle();
            mid();
            check("R7", "empty after drain; dropped insert absent", disp_valid_o, 0);
            tick();
        end

        // Flush
        idle(); insert(6'd20, 0, '0, 5'd6, 1, 16'h0020, 5'd0); tick();
        idle(); insert(6'd21, 0, '0, 5'd6, 1, 16'h0021, 5'd0); tick();
        idle(); flush_i = 1; bus(5'd6, 16'h0066);
        insert(6'd2, 1, 16'h0002, 5'd0, 1, 16'h0002, 5'd0);
        mid();
        check("R10", "no dispatch in flush cycle", disp_valid_o, 0);
        tick();
        idle(); bus(5'd6, 16'h0066);
        mid();
        check("R10", "nothing left after flush", disp_valid_o, 0);
        check("R10", "full after flush", full_o, 0);
        tick();
        idle(); insert(6'd4, 1, 16'h0404, 5'd0, 1, 16'h0505, 5'd0); tick();
        idle();
        mid();
        check("R2", "insert after flush dispatches", disp_valid_o, 1);
        check("R2", "insert after flush value", disp_a_o, 32'h0404);
        tick();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule